// File: doc/BRIEF.md
# Lifecycle State Transition Controller

This block holds the lifecycle state of a device and moves it forward along a fixed, one-way graph of five states. Software loads a 256-bit authentication token as eight 32-bit words through a simple register write port. It then writes a transition code. That last write starts an attempt. The controller checks two things. The code must name an edge that leaves the current state. The loaded token must equal the expected token, which arrives on an input port from an external keyed-hash engine.

When both checks pass, the controller updates its state and emits a one-cycle program strobe carrying the new state encoding, for the persistent storage to record. It also raises a done flag. When either check fails, the state is kept and an error flag is raised. In both cases the token words are wiped when the attempt ends.

The state comes out of reset from an input that carries the persisted value. The token compare always walks every word, so an attempt takes the same number of cycles wherever a mismatch lies.

Top module: `lc_xition_ctrl`

## Requirements
- R1: During reset the current state loads from `persist_state`. An encoding above 4 loads as EOL. After reset, busy, done, error and the program strobe are all 0.
- R2: The state encodings are DEV=0, PROD=1, LOCKED=2, RMA=3 and EOL=4. The command register is at offset 0x100, and its code sits in bits [3:0]. Token word i (i=0..7) is at offset 0x104+4*i and is compared with `exp_token[32*i+31:32*i]`.
- R3: The accepted codes are 1 (DEV to PROD), 2 (PROD to LOCKED), 3 (PROD to RMA), 4 (LOCKED to RMA) and 5 (RMA to EOL). A code whose source state matches, together with a matching token, commits on the 9th rising edge after the edge that takes the command write. On that edge `prog_stb` pulses high for exactly one cycle with `prog_state` equal to the new state, the current state changes to that state, and done is set.
- R4: A code whose source state differs from the current state, or a code not listed in R3, sets error. The state does not change and no strobe is issued.
- R5: A mismatch in any single token word sets error. The attempt has the same 9-cycle latency whether the mismatch is in the first word or the last.
- R6: The state never returns to DEV, and EOL accepts no transition.
- R7: When any attempt ends, pass or fail, all eight token words are zero.
- R8: Register writes arriving while busy is high are dropped, both token words and commands.
- R9: Done and error keep their values until the next command is accepted, and both clear on that edge. They are never high together.
- R10: Writes to offsets other than the command register and the eight token words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| persist_state | input | 3 | Persisted lifecycle state, loaded during reset |
| exp_token | input | 256 | Expected authentication token |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| cur_state | output | 3 | Current lifecycle state |
| busy | output | 1 | An attempt is in progress |
| done | output | 1 | The last attempt committed |
| err | output | 1 | The last attempt was rejected |
| prog_stb | output | 1 | One-cycle program strobe for persistent storage |
| prog_state | output | 3 | State encoding to program, valid with `prog_stb` |

## Verification
The bench builds the block with its default parameters: eight 32-bit token words, a 12-bit offset and the command register at 0x100. That gives a fixed attempt latency of nine cycles, which the scoreboard predicts for every attempt. With eight words, the bench can place a mismatch in the first word and in the last word and confirm the latency does not change. Repeated resets with different persisted values put every source state, including the out-of-range encodings, within reach.

// File: rtl/lcx_pkg.sv
package lcx_pkg;

  typedef enum logic [2:0] {
    LC_DEV    = 3'd0,
    LC_PROD   = 3'd1,
    LC_LOCKED = 3'd2,
    LC_RMA    = 3'd3,
    LC_EOL    = 3'd4
  } lc_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMP  = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;

  // Out-of-range persisted encodings fall to the most restrictive state.
  function automatic lc_state_e lc_sanitize(input logic [2:0] raw);
    if (raw > 3'd4) return LC_EOL;
    return lc_state_e'(raw);
  endfunction

  // Source state that a transition code requires.
  function automatic logic edge_legal(input lc_state_e cur, input logic [3:0] code);
    case (code)
      4'h1: return cur == LC_DEV;
      4'h2: return cur == LC_PROD;
      4'h3: return cur == LC_PROD;
      4'h4: return cur == LC_LOCKED;
      4'h5: return cur == LC_RMA;
      default: return 1'b0;
    endcase
  endfunction

  // Destination state of a transition code.
  function automatic lc_state_e edge_dest(input logic [3:0] code);
    case (code)
      4'h1: return LC_PROD;
      4'h2: return LC_LOCKED;
      4'h3: return LC_RMA;
      4'h4: return LC_RMA;
      default: return LC_EOL;
    endcase
  endfunction

endpackage

// File: rtl/lcx_regfile.sv
module lcx_regfile #(
  parameter int TOK_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CMD_OFS   = 'h100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  input  logic                        accept,
  input  logic                        clr,
  output logic [TOK_WORDS*WORD_W-1:0] tok_flat,
  output logic                        cmd_fire,
  output logic [3:0]                  cmd_code
);

  localparam int BYTES_PER_WORD = WORD_W / 8;

  assign cmd_fire = we && accept && (addr == ADDR_W'(CMD_OFS));
  assign cmd_code = wdata[3:0];

  for (genvar i = 0; i < TOK_WORDS; i++) begin : g_tok
    localparam int OFS = CMD_OFS + BYTES_PER_WORD * (i + 1);
    logic hit;
    assign hit = we && accept && (addr == ADDR_W'(OFS));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tok_flat[i*WORD_W +: WORD_W] <= '0;
      else if (clr) tok_flat[i*WORD_W +: WORD_W] <= '0;
      else if (hit) tok_flat[i*WORD_W +: WORD_W] <= wdata;
    end
  end

endmodule

// File: rtl/lcx_tok_cmp.sv
module lcx_tok_cmp #(
  parameter int TOK_WORDS = 8,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        step,
  input  logic [TOK_WORDS*WORD_W-1:0] got,
  input  logic [TOK_WORDS*WORD_W-1:0] want,
  output logic                        last,
  output logic                        mismatch
);

  localparam int IDX_W = (TOK_WORDS > 1) ? $clog2(TOK_WORDS) : 1;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] got_w, want_w;
  logic              acc;

  // One word per cycle, every word visited: constant time.
  assign got_w    = got[idx*WORD_W +: WORD_W];
  assign want_w   = want[idx*WORD_W +: WORD_W];
  assign last     = (idx == IDX_W'(TOK_WORDS - 1));
  assign mismatch = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= 1'b0;
    end else if (start) begin
      idx <= '0;
      acc <= 1'b0;
    end else if (step) begin
      acc <= acc | (|(got_w ^ want_w));
      idx <= last ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/lcx_seq.sv
module lcx_seq
  import lcx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] persist_state,
  input  logic       cmd_fire,
  input  logic [3:0] cmd_code,
  input  logic       cmp_last,
  input  logic       cmp_bad,
  output lc_state_e  cur_state,
  output logic       busy,
  output logic       cmp_start,
  output logic       cmp_step,
  output logic       tok_clr,
  output logic       prog_stb,
  output lc_state_e  prog_state,
  output logic       done,
  output logic       err
);

  phase_e     phase;
  logic [3:0] code_q;
  logic       commit_ok;

  assign busy      = (phase != PH_IDLE);
  assign cmp_start = (phase == PH_IDLE) && cmd_fire;
  assign cmp_step  = (phase == PH_CMP);
  assign tok_clr   = (phase == PH_FIN);
  assign commit_ok = edge_legal(cur_state, code_q) && !cmp_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      code_q     <= '0;
      cur_state  <= lc_sanitize(persist_state);
      prog_stb   <= 1'b0;
      prog_state <= LC_DEV;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      prog_stb <= 1'b0;
      case (phase)
        PH_IDLE: if (cmd_fire) begin
          code_q <= cmd_code;
          done   <= 1'b0;
          err    <= 1'b0;
          phase  <= PH_CMP;
        end
        PH_CMP: if (cmp_last) phase <= PH_FIN;
        PH_FIN: begin
          if (commit_ok) begin
            cur_state  <= edge_dest(code_q);
            prog_state <= edge_dest(code_q);
            prog_stb   <= 1'b1;
            done       <= 1'b1;
          end else begin
            err <= 1'b1;
          end
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lc_xition_ctrl.sv
module lc_xition_ctrl
  import lcx_pkg::*;
#(
  parameter int TOK_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int CMD_OFS   = 'h100
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  persist_state,
  input  logic [TOK_WORDS*WORD_W-1:0] exp_token,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  output logic [2:0]                  cur_state,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic                        prog_stb,
  output logic [2:0]                  prog_state
);

  // Named internal events, visible to the bound checker.
  logic [TOK_WORDS*WORD_W-1:0] tok_flat;
  logic                        cmd_fire;
  logic [3:0]                  cmd_code;
  logic                        cmp_start, cmp_step, cmp_last, cmp_bad;
  logic                        tok_clr;
  lc_state_e                   st_q, prog_q;

  lcx_regfile #(
    .TOK_WORDS(TOK_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .accept(!busy), .clr(tok_clr), .tok_flat(tok_flat),
    .cmd_fire(cmd_fire), .cmd_code(cmd_code)
  );

  lcx_tok_cmp #(.TOK_WORDS(TOK_WORDS), .WORD_W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .start(cmp_start), .step(cmp_step),
    .got(tok_flat), .want(exp_token), .last(cmp_last), .mismatch(cmp_bad)
  );

  lcx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .persist_state(persist_state),
    .cmd_fire(cmd_fire), .cmd_code(cmd_code),
    .cmp_last(cmp_last), .cmp_bad(cmp_bad),
    .cur_state(st_q), .busy(busy), .cmp_start(cmp_start), .cmp_step(cmp_step),
    .tok_clr(tok_clr), .prog_stb(prog_stb), .prog_state(prog_q),
    .done(done), .err(err)
  );

  assign cur_state  = st_q;
  assign prog_state = prog_q;

endmodule

// File: rtl/lcx_checker.sv
module lcx_checker #(
  parameter int TOK_WORDS = 8,
  parameter int WORD_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2:0]                  cur_state,
  input logic                        busy,
  input logic                        done,
  input logic                        err,
  input logic                        prog_stb,
  input logic [2:0]                  prog_state,
  input logic [TOK_WORDS*WORD_W-1:0] tok_flat
);

  logic [15:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 16'd1;
    else           busy_run <= '0;
  end

  assert_stb_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  assert_stb_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (prog_state == cur_state) && done);

  assert_state_needs_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != $past(cur_state)) |-> prog_stb);

  assert_const_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 16'(TOK_WORDS + 1)));

  assert_no_dev_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state != 3'd0) |=> (cur_state != 3'd0));

  assert_eol_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd4) |=> (cur_state == 3'd4));

  assert_token_wiped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tok_flat == '0));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

endmodule

bind lc_xition_ctrl lcx_checker #(.TOK_WORDS(TOK_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_state(cur_state), .busy(busy), .done(done),
  .err(err), .prog_stb(prog_stb), .prog_state(prog_state), .tok_flat(tok_flat)
);

// File: tb/test_lc_xition_ctrl.sv
module test_lc_xition_ctrl;

  typedef struct {
    logic [2:0] st;
    logic       fail;
    int         cyc;
    string      req;
  } exp_item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   persist_state = 3'd0;
  logic [255:0] exp_token = '0;
  logic         reg_we = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [2:0]   cur_state, prog_state;
  logic         busy, done, err, prog_stb;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [2:0] model_st;
  logic prev_busy = 1'b0;
  exp_item_t sb[$];

  lc_xition_ctrl i_lc_xition_ctrl (
    .clk(clk), .rst_n(rst_n), .persist_state(persist_state), .exp_token(exp_token),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cur_state(cur_state), .busy(busy), .done(done), .err(err),
    .prog_stb(prog_stb), .prog_state(prog_state)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [255:0] mk_tok(input logic [31:0] seed);
    logic [255:0] t;
    for (int i = 0; i < 8; i++) t[32*i +: 32] = seed ^ (32'h0101_0101 * (i + 1));
    return t;
  endfunction

  // Bench's own view of the transition graph (R3).
  function automatic logic [3:0] model_next(input logic [2:0] s, input logic [3:0] code);
    // returns {legal, dest}
    case ({s, code})
      {3'd0, 4'h1}: return {1'b1, 3'd1};
      {3'd1, 4'h2}: return {1'b1, 3'd2};
      {3'd1, 4'h3}: return {1'b1, 3'd3};
      {3'd2, 4'h4}: return {1'b1, 3'd3};
      {3'd3, 4'h5}: return {1'b1, 3'd4};
      default:      return {1'b0, s};
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int cap);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cap = cyc;
    reg_we = 1'b0;
  endtask

  task automatic load_tok(input logic [255:0] t);
    int c;
    for (int i = 0; i < 8; i++) wr(12'h104 + 12'(4 * i), t[32*i +: 32], c);
  endtask

  // Driver: issues a command and pushes the predicted outcome.
  task automatic attempt(input logic [3:0] code, input logic tok_ok, input string req);
    int c;
    logic [3:0] nx;
    exp_item_t it;
    nx = model_next(model_st, code);
    it.fail = !(nx[3] && tok_ok);
    it.st   = it.fail ? model_st : nx[2:0];
    it.req  = req;
    wr(12'h100, {28'h0, code}, c);
    it.cyc = c + 9;
    sb.push_back(it);
    check("R9", "done cleared on accept", int'(done), 0);
    check("R9", "err cleared on accept", int'(err), 0);
    check(req, "busy after accept", int'(busy), 1);
    model_st = it.st;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] p, input logic [2:0] expect_st);
    @(negedge clk);
    rst_n = 1'b0; persist_state = p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_st = expect_st;
    check("R1", "reset state", int'(cur_state), int'(expect_st));
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset flags", int'({done, err, prog_stb}), 0);
  endtask

  // Monitor: pops a prediction at each attempt completion.
  always @(negedge clk) begin
    if (!rst_n) prev_busy = 1'b0;
    else begin
      if (prev_busy && !busy) begin
        if (sb.size() == 0) check("R8", "unexpected attempt", 1, 0);
        else begin
          exp_item_t it;
          it = sb.pop_front();
          check(it.req, "latency", cyc, it.cyc);
          check(it.req, "state", int'(cur_state), int'(it.st));
          check(it.req, "err", int'(err), int'(it.fail));
          check(it.req, "done", int'(done), int'(!it.fail));
          check(it.req, "strobe", int'(prog_stb), int'(!it.fail));
          if (!it.fail) check(it.req, "prog_state", int'(prog_state), int'(it.st));
        end
      end
      prev_busy = busy;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] t;
    int c;
    t = mk_tok(32'hC3A5_1E00);
    exp_token = t;
    do_reset(3'd0, 3'd0);

    // R4: wrong source state, then unlisted code
    load_tok(t); attempt(4'h2, 1'b1, "R4"); drain();
    load_tok(t); attempt(4'h9, 1'b1, "R4"); drain();
    // R3/R2: legal DEV->PROD with every word in place
    load_tok(t); attempt(4'h1, 1'b1, "R3"); drain();
    // R9: done holds after completion
    repeat (3) @(negedge clk);
    check("R9", "done sticky", int'(done), 1);
    // R5: mismatch in first word, then in last word
    load_tok(t ^ 256'h1); attempt(4'h2, 1'b0, "R5"); drain();
    load_tok(t ^ (256'h1 << 255)); attempt(4'h2, 1'b0, "R5"); drain();
    check("R5", "state kept", int'(cur_state), 1);
    // R10: stray writes; R7: token wiped, so zero expected token matches
    wr(12'h124, 32'hFFFF_FFFF, c);
    wr(12'h0FC, 32'h0000_0001, c);
    wr(12'h000, 32'h0000_0002, c);
    check("R10", "no attempt from stray write", int'(busy), 0);
    exp_token = '0;
    attempt(4'h2, 1'b1, "R7"); drain();
    // R8: writes during busy are dropped
    exp_token = t;
    load_tok(t); attempt(4'h4, 1'b1, "R8");
    wr(12'h104, 32'hDEAD_BEEF, c);
    wr(12'h100, 32'h0000_0005, c);
    drain();
    repeat (2) @(negedge clk);
    check("R8", "busy idle after drop", int'(busy), 0);
    exp_token = '0;
    attempt(4'h5, 1'b1, "R8"); drain();
    check("R6", "reached EOL", int'(cur_state), 4);
    // R6: EOL takes nothing
    attempt(4'h1, 1'b1, "R6"); drain();
    attempt(4'h5, 1'b1, "R6"); drain();
    // R1: out-of-range persisted value loads as EOL
    do_reset(3'd7, 3'd4);
    // R6: no way back to DEV from RMA; RMA->EOL still legal
    do_reset(3'd3, 3'd3);
    exp_token = t;
    load_tok(t); attempt(4'h1, 1'b1, "R6"); drain();
    load_tok(t); attempt(4'h5, 1'b1, "R3"); drain();
    // R3: PROD->RMA edge
    do_reset(3'd1, 3'd1);
    load_tok(t); attempt(4'h3, 1'b1, "R3"); drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule